// File: doc/BRIEF.md
# ECC-Integrated Silent Store Squasher

This block sits on the commit-side write path of a data array whose 64-bit words each carry 8 check bits of a SEC-DED Hamming code. A 64-bit store replaces a whole protected word, so the block encodes it and writes it directly. A 32-bit store changes only one half of a word. The check bits cover the whole word, so the old word has to be read first. The block reuses that mandatory read to compare the old half with the incoming data. If the two match and the read word shows no ECC error, the write is cancelled and a one-cycle squash pulse reports a silent store. Otherwise the new half is merged into the old word, fresh check bits are computed, and the word is written back. The check happens at commit, with no separate load operation.

Requests use a valid/ready handshake and are handled one at a time by a four-state machine:
- ST_IDLE: ready is high. An accepted 64-bit store moves to ST_WRITE. An accepted 32-bit store moves to ST_READ.
- ST_READ: the word read is issued. The machine always moves on to ST_CMP.
- ST_CMP: the read word is on `mem_rdata` and is checked and compared. A silent store returns to ST_IDLE. A changing store moves to ST_WRITE.
- ST_WRITE: the encoded word is written. The machine always returns to ST_IDLE.

The array is an external synchronous memory. Its read data appears one cycle after a read enable. The block keeps two counters: one for squashed stores and one for written stores.

Top module: `silent_store_squasher`

## Requirements
- R1: After reset, `req_ready` is 1. `done`, `squash`, `ecc_err`, `mem_en` and `mem_we` are 0. Both counters are 0.
- R2: `req_ready` is 1 only in the idle state. A `req_valid` presented while `req_ready` is 0 is ignored and causes no memory access.
- R3: A 64-bit store (`req_size`=1) is written in the cycle after acceptance, with `mem_en`=1 and `mem_we`=1, at word `req_addr[ADDR_W:1]`. It issues no read and never squashes. `done` pulses in that same cycle.
- R4: A 32-bit store (`req_size`=0) issues a read (`mem_en`=1, `mem_we`=0) at word `req_addr[ADDR_W:1]` in the cycle after acceptance. The following cycle is the compare cycle and makes no memory access.
- R5: `req_addr` counts 32-bit slots. Bit 0 picks the half: 0 selects data bits 31:0 and 1 selects bits 63:32. A 32-bit store takes its data from `req_data[31:0]`.
- R6: If the selected old half equals the new data and the read word has no ECC error, `squash` and `done` pulse together in the compare cycle, 2 cycles after acceptance. The write is cancelled.
- R7: Otherwise the merged word is written 3 cycles after acceptance, to the same word address. The other half is unchanged, and `done` pulses in that cycle.
- R8: `mem_wdata` = {check[7:0], data[63:0]}. Data bit i sits at the i-th codeword position, counting from 3 upward and skipping powers of two. check[b] (b<7) is the XOR of the data bits whose position has bit b set. check[7] is the XOR of all 64 data bits and check[6:0].
- R9: `ecc_err` pulses in the compare cycle when the read word's recomputed syndrome is nonzero or its overall parity is odd. Such a store is never squashed and is written with fresh check bits.
- R10: `squash_cnt` increments one cycle after each squash pulse. `write_cnt` increments one cycle after each `done` without squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request valid |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_addr | input | ADDR_W+1 | 32-bit slot address; bit 0 selects the half |
| req_data | input | 64 | Store data (bits 31:0 for a 32-bit store) |
| req_size | input | 1 | 0 = 32-bit store, 1 = 64-bit store |
| done | output | 1 | One-cycle pulse when a store completes |
| squash | output | 1 | One-cycle pulse when a store is cancelled as silent |
| ecc_err | output | 1 | Read word failed its ECC check in the compare cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 72 | Check bits and data to write |
| mem_rdata | input | 72 | Read word, valid one cycle after a read |
| squash_cnt | output | CNT_W | Count of squashed stores |
| write_cnt | output | CNT_W | Count of written stores |

## Verification
For a 64-bit store, the write and `done` are due one cycle after the accepting edge. For a 32-bit store, the read is due one cycle after acceptance, the compare result with `squash` or `ecc_err` two cycles after, and the write three cycles after. The counters follow one cycle after `done`. The bench owns the memory and a behavioural reference of the word contents. It drives each store on a falling edge and compares every output on the falling edge of each cycle of the transaction, and of the idle cycle that follows, against the value due in that cycle. Corrupted words are preloaded into the bench memory to exercise error detection. Requests are also pulsed while the block is busy, to show they are ignored.

// File: rtl/sss_pkg.sv
package sss_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int WORD_W = DATA_W + CHK_W;
    localparam int HALF_W = DATA_W / 2;
    localparam int HAM_W  = CHK_W - 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CMP,
        ST_WRITE
    } sss_state_t;

    // Hamming check bits over the data word plus an overall parity bit.
    function automatic logic [CHK_W-1:0] sss_check_bits(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        int               pos;
        c   = '0;
        pos = 2;
        for (int i = 0; i < DATA_W; i++) begin
            pos = pos + 1;
            if ((pos & (pos - 1)) == 0) pos = pos + 1;
            for (int b = 0; b < HAM_W; b++) begin
                if (pos[b]) c[b] = c[b] ^ d[i];
            end
        end
        c[CHK_W-1] = (^d) ^ (^c[HAM_W-1:0]);
        return c;
    endfunction
endpackage

// File: rtl/sss_ecc_enc.sv
module sss_ecc_enc
    import sss_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = {sss_check_bits(data), data};
    end
endmodule

// File: rtl/sss_ecc_det.sv
module sss_ecc_det
    import sss_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              err
);
    logic [CHK_W-1:0] recomputed;
    logic [HAM_W-1:0] syndrome;
    logic             parity_odd;

    always_comb begin
        recomputed = sss_check_bits(word[DATA_W-1:0]);
        syndrome   = recomputed[HAM_W-1:0] ^ word[DATA_W+HAM_W-1:DATA_W];
        parity_odd = ^word;
        err        = (|syndrome) | parity_odd;
    end
endmodule

// File: rtl/sss_merge.sv
module sss_merge
    import sss_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [HALF_W-1:0] new_half,
    input  logic              sel,
    output logic [DATA_W-1:0] merged,
    output logic              same
);
    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_eq[g] = (old_word[g*HALF_W +: HALF_W] == new_half);
            merged[g*HALF_W +: HALF_W] = (int'(sel) == g) ? new_half
                                                          : old_word[g*HALF_W +: HALF_W];
        end
    end

    always_comb begin
        same = lane_eq[sel];
    end
endmodule

// File: rtl/silent_store_squasher.sv
module silent_store_squasher
    import sss_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [63:0]       req_data,
    input  logic              req_size,
    output logic              done,
    output logic              squash,
    output logic              ecc_err,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [71:0]       mem_wdata,
    input  logic [71:0]       mem_rdata,
    output logic [CNT_W-1:0]  squash_cnt,
    output logic [CNT_W-1:0]  write_cnt
);
    sss_state_t        state_q, state_d;
    logic [ADDR_W-1:0] waddr_q;
    logic              sel_q;
    logic [HALF_W-1:0] half_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] merged;
    logic              same_half;
    logic              rd_err;
    logic              silent;
    logic              accept;
    logic [WORD_W-1:0] enc_word;

    sss_ecc_enc u_enc (
        .data (wdata_q),
        .word (enc_word)
    );

    sss_ecc_det u_det (
        .word (mem_rdata),
        .err  (rd_err)
    );

    sss_merge #(.LANES(2)) u_merge (
        .old_word (mem_rdata[DATA_W-1:0]),
        .new_half (half_q),
        .sel      (sel_q),
        .merged   (merged),
        .same     (same_half)
    );

    assign accept = req_valid && req_ready;
    assign silent = same_half && !rd_err;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = req_size ? ST_WRITE : ST_READ;
            ST_READ:  state_d = ST_CMP;
            ST_CMP:   state_d = silent ? ST_IDLE : ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        squash    = 1'b0;
        ecc_err   = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = waddr_q;
        mem_wdata = enc_word;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_READ:  mem_en = 1'b1;
            ST_CMP: begin
                ecc_err = rd_err;
                squash  = silent;
                done    = silent;
            end
            ST_WRITE: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
                done   = 1'b1;
            end
            default: ;
        endcase
    end

    // Request capture and merge register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr_q <= '0;
            sel_q   <= 1'b0;
            half_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            waddr_q <= req_addr[ADDR_W:1];
            sel_q   <= req_addr[0];
            half_q  <= req_data[HALF_W-1:0];
            wdata_q <= req_data;
        end else if (state_q == ST_CMP) begin
            wdata_q <= merged;
        end
    end

    // Outcome counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            squash_cnt <= '0;
            write_cnt  <= '0;
        end else if (done) begin
            if (squash) squash_cnt <= squash_cnt + 1'b1;
            else        write_cnt  <= write_cnt + 1'b1;
        end
    end

    AST_ACCEPT_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> mem_en && !req_ready); // R3
    AST_READ_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> !mem_en && !req_ready); // R4
    AST_SQUASH_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> $past(mem_en && !mem_we)); // R6
    AST_SQUASH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> req_ready && !mem_en); // R6
    AST_WRITE_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_en && !mem_we, 2)) |-> mem_addr == $past(mem_addr, 2)); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !req_ready); // R2
    AST_SQUASH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> squash_cnt == $past(squash_cnt) + 1'b1); // R10
    AST_WRITE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !squash) |=> write_cnt == $past(write_cnt) + 1'b1); // R10
endmodule

// File: tb/silent_store_squasher_test.sv
module silent_store_squasher_test;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 16;
    localparam int NW     = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W:0]   req_addr = '0;
    logic [63:0]       req_data = '0;
    logic              req_size = 1'b0;
    logic              done, squash, ecc_err, mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [71:0]       mem_wdata;
    logic [71:0]       mem_rdata = '0;
    logic [CNT_W-1:0]  squash_cnt, write_cnt;

    logic [71:0] mem [NW];
    logic [71:0] gold [NW];
    int checks = 0;
    int errors = 0;
    int exp_sq = 0;
    int exp_wr = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    silent_store_squasher #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_size(req_size),
        .done(done), .squash(squash), .ecc_err(ecc_err), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .squash_cnt(squash_cnt), .write_cnt(write_cnt)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    // Codeword built position by position from the definition in R8.
    function automatic logic [71:0] encode(input logic [63:0] d);
        logic [7:0] c = '0;
        int k = 0;
        for (int p = 1; p < 72 && k < 64; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int b = 0; b < 7; b++) if ((p >> b) & 1) c[b] ^= d[k];
                k++;
            end
        end
        c[7] = ^{d, c[6:0]};
        return {c, d};
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check({req, " ready"}, 72'(req_ready), 72'(1));
        check({req, " done"}, 72'(done), 72'(0));
        check({req, " squash"}, 72'(squash), 72'(0));
        check({req, " mem_en"}, 72'(mem_en), 72'(0));
        check({req, " sq_cnt"}, 72'(squash_cnt), 72'(exp_sq));
        check({req, " wr_cnt"}, 72'(write_cnt), 72'(exp_wr));
    endtask

    // Drive on a falling edge; every output is sampled on falling edges.
    task automatic do_store(input logic [ADDR_W:0] a, input logic [63:0] d,
                            input logic sz, input bit poke);
        int w = int'(a[ADDR_W:1]);
        logic [63:0] old = gold[w][63:0];
        logic [63:0] mrg = old;
        logic bad = (encode(old) !== gold[w]);
        logic sil;
        if (a[0]) mrg[63:32] = d[31:0]; else mrg[31:0] = d[31:0];
        sil = !sz && !bad && (mrg == old);
        req_valid = 1; req_addr = a; req_data = d; req_size = sz;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        if (sz) begin
            check("R3 write en", {mem_en, mem_we, done, squash}, 4'b1110);
            check("R3 addr", 72'(mem_addr), 72'(w));
            check("R8 wdata", mem_wdata, encode(d));
            gold[w] = encode(d); exp_wr++;
        end else begin
            check("R4 read", {mem_en, mem_we, done, req_ready}, 4'b1000);
            check("R4 addr", 72'(mem_addr), 72'(w));
            if (poke) begin
                req_valid = 1; req_size = 1; req_addr = a ^ 1; req_data = ~d;
            end
            @(negedge clk);
            req_valid = 0;
            check("R2 ready low", 72'(req_ready), 72'(0));
            check("R4 quiet", 72'(mem_en), 72'(0));
            check("R9 ecc_err", 72'(ecc_err), 72'(bad));
            check("R6 squash", {squash, done}, {sil, sil});
            if (sil) begin
                exp_sq++;
            end else begin
                @(negedge clk);
                check("R7 write", {mem_en, mem_we, done, squash}, 4'b1110);
                check("R7 addr", 72'(mem_addr), 72'(w));
                check("R5 R7 R8 merged", mem_wdata, encode(mrg));
                gold[w] = encode(mrg); exp_wr++;
            end
        end
        @(negedge clk);
        check_idle("R10 R2 after store");
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            gold[i] = encode(64'h0123_4567_89ab_cdef ^ (64'(i) * 64'h1111_0003_0000_0101));
            mem[i]  = gold[i];
        end
        gold[5] = gold[5] ^ 72'h1 << 40;       // single-bit data flip
        mem[5]  = gold[5];
        gold[6] = gold[6] ^ 72'h3 << 65;       // double-bit check flip
        mem[6]  = gold[6];
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready", 72'(req_ready), 72'(1));
        check("R1 outs", {done, squash, ecc_err, mem_en, mem_we}, 5'b0);
        check("R1 cnts", {squash_cnt, write_cnt}, '0);
        rst_n = 1;
        @(negedge clk);
        check_idle("R1 post reset");

        do_store(5'd2, 64'hdead_beef_cafe_f00d, 1'b1, 0);           // R3 full
        do_store(5'd2, 64'h0000_0000_cafe_f00d, 1'b0, 0);           // R6 lower silent
        do_store(5'd3, 64'h0000_0000_dead_beef, 1'b0, 1);           // R6 upper silent + R2 poke
        do_store(5'd3, 64'h0000_0000_1234_5678, 1'b0, 1);           // R7 upper change + R2 poke
        do_store(5'd2, 64'h0000_0000_1234_5678, 1'b0, 0);           // R5 R7 lower change
        do_store(5'd2, 64'h1234_5678_1234_5678, 1'b1, 0);           // R3 full, same data: no squash
        do_store(5'd0, {32'h0, gold[0][31:0]}, 1'b0, 0);            // R6 silent on preloaded word
        do_store(5'd11, {32'h0, gold[5][63:32]}, 1'b0, 0);          // R9 single error, not squashed
        do_store(5'd12, {32'h0, gold[6][31:0]}, 1'b0, 0);           // R9 double error, not squashed
        do_store(5'd31, 64'h0, 1'b0, 0);                            // R7 top word upper half
        do_store(5'd31, 64'h0, 1'b0, 0);                            // R6 repeat is silent
        for (int i = 0; i < 20; i++) begin
            logic [ADDR_W:0] a = 5'((i * 7) & 31);
            do_store(a, (i % 3 == 0) ? 64'(i) : gold[int'(a[ADDR_W:1])] >> (a[0] ? 32 : 0),
                     1'b0, i[0]);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule